// File: doc/BRIEF.md
# Always-On Time Counter with Control Word

This block keeps a 47-bit time count that moves forward by one on each tick of a 32768 Hz time base, shown here as a one-cycle `tick_en` strobe in the system clock domain. Software reaches the count through two windows: an upper window carrying the top 15 bits and a lower window carrying the bottom 32 bits. A write to either window patches that part of the running count without stopping it, so the next tick continues from the patched value.

A 32-bit control word sits beside the count. It keeps whatever was last written to it and returns it on read. When one write to it has both the power-off-enable bit and the turn-off-power bit set, the block sends out a one-cycle power-off request. The register bus is single-cycle: an address, a write strobe, write data and a read-data path that follows the address in the same cycle. The window covers 4 KiB of byte addresses. Addresses that do not decode read as zero and ignore writes.

Top module: `slowtime_counter`

## Requirements
- R1: After a synchronous active-low reset the count is zero, the control word is zero and `pwroff_req` is low.
- R2: Each cycle with `tick_en` high and no count write raises the count by exactly one. A cycle with neither changes nothing.
- R3: A read at byte offset 0x54 returns count bits 31..0. A read at 0x50 returns count bits 46..32 in data bits 14..0, with data bits 31..15 zero.
- R4: A write at 0x54 replaces count bits 31..0 with the write data and leaves count bits 46..32 unchanged.
- R5: A write at 0x50 replaces count bits 46..32 with write-data bits 14..0, discards write-data bits 31..15 and leaves count bits 31..0 unchanged.
- R6: Counting goes on after a count write, starting from the written value. A tick in the same cycle as a count write is dropped and the written value is kept.
- R7: A tick carries from bit 31 into bit 32. A tick with the count all ones wraps it to zero.
- R8: A write at 0x38 stores all 32 data bits in the control word, and a read at 0x38 returns them.
- R9: `pwroff_req` is high for exactly the one cycle after the edge that accepts a write at 0x38 whose data has bit 5 and bit 6 both set. A write with only one of them set, or to any other offset, gives no pulse.
- R10: A read at any offset other than 0x38, 0x50 and 0x54 returns zero. A write there changes neither the count nor the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle strobe at the 32768 Hz rate |
| bus_addr | input | 12 | Byte offset inside the 4 KiB window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| pwroff_req | output | 1 | One-cycle power-off request |

## Verification
Read data follows the address in the same cycle. A count or control word that has gone wrong therefore shows up at the next read of its window, and the bench reads a window after every random step. A lost carry between the halves only shows once the lower half rolls over, so the bench places values near 0xFFFFFFFF and near all ones before it ticks. A wrong pulse qualifier or a pulse that stays high shows at `pwroff_req` one cycle after the write, and the bench compares that pin on every cycle.

// File: rtl/slowtime_pkg.sv
// Package: shared types for the time counter block.
// Assumes: only the three decoded register slots plus "none" are needed.
package slowtime_pkg;

    // Register slot chosen by the address decoder
    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_CNT_HI = 2'd1,
        SLOT_CNT_LO = 2'd2,
        SLOT_CTRL   = 2'd3
    } slot_e;

endpackage

// File: rtl/slowtime_decode.sv
// Module: address decoder for the time counter window.
// Maps a full byte offset onto one register slot. Any offset that does not
// match exactly gives SLOT_NONE.
// Assumes: the offsets are distinct and fit in ADDR_W bits.
module slowtime_decode
    import slowtime_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned OFF_HI   = 'h50,
    parameter int unsigned OFF_LO   = 'h54,
    parameter int unsigned OFF_CTRL = 'h38
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_e             slot
);

    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFF_HI);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFF_LO);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

    // Compare the offset against each register address
    always_comb begin
        if (addr == A_HI) begin
            slot = SLOT_CNT_HI;
        end else if (addr == A_LO) begin
            slot = SLOT_CNT_LO;
        end else if (addr == A_CTRL) begin
            slot = SLOT_CTRL;
        end else begin
            slot = SLOT_NONE;
        end
    end

endmodule

// File: rtl/slowtime_count.sv
// Module: the running time count.
// Holds a CNT_W-bit count. A tick adds one to it. A write to either half
// patches that half in place, and a write takes priority over a tick in the
// same cycle. SPLIT_INC picks the increment: a split adder (lower half plus a
// carry-gated upper half) or one flat adder. Both give the same result.
// Assumes: LO_W <= DATA_W and CNT_W - LO_W <= DATA_W; wr_hi and wr_lo are
// never high together.
module slowtime_count #(
    parameter int unsigned CNT_W     = 47,
    parameter int unsigned LO_W      = 32,
    parameter int unsigned DATA_W    = 32,
    parameter bit          SPLIT_INC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q
);

    localparam int unsigned HI_W = CNT_W - LO_W;

    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_nxt;

    generate
        if (SPLIT_INC) begin : g_split
            logic [LO_W-1:0] lo_inc;
            logic [HI_W-1:0] hi_inc;
            logic            lo_full;
            // Lower half plus one, and the upper half stepped only on carry
            always_comb begin
                lo_full = &cnt_q[LO_W-1:0];
                lo_inc  = cnt_q[LO_W-1:0] + LO_W'(1);
                hi_inc  = cnt_q[CNT_W-1:LO_W] + HI_W'(lo_full);
                cnt_inc = {hi_inc, lo_inc};
            end
        end else begin : g_flat
            // One adder over the whole count
            always_comb begin
                cnt_inc = cnt_q + CNT_W'(1);
            end
        end
    endgenerate

    // Choose the next count: a patch wins over a tick
    always_comb begin
        cnt_nxt = cnt_q;
        if (wr_lo) begin
            cnt_nxt = {cnt_q[CNT_W-1:LO_W], wdata[LO_W-1:0]};
        end else if (wr_hi) begin
            cnt_nxt = {wdata[HI_W-1:0], cnt_q[LO_W-1:0]};
        end else if (tick) begin
            cnt_nxt = cnt_inc;
        end
    end

    // Count register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/slowtime_ctrl.sv
// Module: control word and power-off request.
// Stores every written bit. A write with both the enable bit and the command
// bit set raises off_req for the single cycle after the edge that takes it.
// Assumes: wr is a one-cycle strobe already qualified by the address.
module slowtime_ctrl #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned EN_BIT  = 5,
    parameter int unsigned CMD_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              off_req_q
);

    logic arm_hit;

    // Both power-off bits present in this write
    always_comb begin
        arm_hit = wr && wdata[EN_BIT] && wdata[CMD_BIT];
    end

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q <= wdata;
        end
    end

    // One-cycle request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_req_q <= 1'b0;
        end else begin
            off_req_q <= arm_hit;
        end
    end

endmodule

// File: rtl/slowtime_counter.sv
// Module: top of the always-on time counter.
// Decodes the register bus, routes writes to the count and control blocks,
// and builds read data in the same cycle from the address. The upper count
// window is zero-extended to the bus width.
// Assumes: a single-cycle bus; one write per cycle; tick_en is already in
// the clk domain.
module slowtime_counter
    import slowtime_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CNT_W     = 47,
    parameter int unsigned LO_W      = 32,
    parameter int unsigned OFF_HI    = 'h50,
    parameter int unsigned OFF_LO    = 'h54,
    parameter int unsigned OFF_CTRL  = 'h38,
    parameter int unsigned EN_BIT    = 5,
    parameter int unsigned CMD_BIT   = 6,
    parameter bit          SPLIT_INC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwroff_req
);

    slot_e             slot;
    logic              wr_hi;
    logic              wr_lo;
    logic              wr_ctrl;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] ctrl_q;

    slowtime_decode #(
        .ADDR_W  (ADDR_W),
        .OFF_HI  (OFF_HI),
        .OFF_LO  (OFF_LO),
        .OFF_CTRL(OFF_CTRL)
    ) u_decode (
        .addr(bus_addr),
        .slot(slot)
    );

    // Write strobes for each slot
    always_comb begin
        wr_hi   = bus_we && (slot == SLOT_CNT_HI);
        wr_lo   = bus_we && (slot == SLOT_CNT_LO);
        wr_ctrl = bus_we && (slot == SLOT_CTRL);
    end

    slowtime_count #(
        .CNT_W    (CNT_W),
        .LO_W     (LO_W),
        .DATA_W   (DATA_W),
        .SPLIT_INC(SPLIT_INC)
    ) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_en),
        .wr_hi(wr_hi),
        .wr_lo(wr_lo),
        .wdata(bus_wdata),
        .cnt_q(cnt_q)
    );

    slowtime_ctrl #(
        .DATA_W (DATA_W),
        .EN_BIT (EN_BIT),
        .CMD_BIT(CMD_BIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_ctrl),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .off_req_q(pwroff_req)
    );

    // Read data selected by slot, zero for undecoded offsets
    always_comb begin
        case (slot)
            SLOT_CNT_HI: bus_rdata = DATA_W'(cnt_q[CNT_W-1:LO_W]);
            SLOT_CNT_LO: bus_rdata = DATA_W'(cnt_q[LO_W-1:0]);
            SLOT_CTRL:   bus_rdata = ctrl_q;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/slowtime_counter_chk.sv
// Module: assertion checker bound to slowtime_counter.
// Watches the bus, the count and the control word over time.
// Assumes: the bind below connects the top's internal cnt_q and ctrl_q.
module slowtime_counter_chk #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_W    = 47,
    parameter int unsigned OFF_HI   = 'h50,
    parameter int unsigned OFF_LO   = 'h54,
    parameter int unsigned OFF_CTRL = 'h38,
    parameter int unsigned EN_BIT   = 5,
    parameter int unsigned CMD_BIT  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pwroff_req,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [DATA_W-1:0] ctrl_q
);

    logic cnt_wr;
    logic ctl_wr;
    logic known;

    // Bus events seen from the checker side
    always_comb begin
        cnt_wr = bus_we && ((bus_addr == ADDR_W'(OFF_HI)) || (bus_addr == ADDR_W'(OFF_LO)));
        ctl_wr = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
        known  = (bus_addr == ADDR_W'(OFF_HI)) || (bus_addr == ADDR_W'(OFF_LO))
              || (bus_addr == ADDR_W'(OFF_CTRL));
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_q == '0) && (ctrl_q == '0) && !pwroff_req);

    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_wr) |=> $stable(cnt_q));

    a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctrl_q));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pwroff_req |=> !pwroff_req);

    a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pwroff_req |-> $past(ctl_wr && bus_wdata[EN_BIT] && bus_wdata[CMD_BIT]));

    a_r10_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (bus_rdata == '0));

endmodule

bind slowtime_counter slowtime_counter_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .OFF_HI  (OFF_HI),
    .OFF_LO  (OFF_LO),
    .OFF_CTRL(OFF_CTRL),
    .EN_BIT  (EN_BIT),
    .CMD_BIT (CMD_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwroff_req(pwroff_req),
    .cnt_q     (cnt_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_slowtime_counter.sv
// Bench: directed corners plus seeded random traffic against a bench model.
module tb_slowtime_counter;

    localparam logic [11:0] A_HI   = 12'h050;
    localparam logic [11:0] A_LO   = 12'h054;
    localparam logic [11:0] A_CTRL = 12'h038;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwroff_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [46:0] m_cnt = '0;
    logic [31:0] m_ctrl = '0;

    always #2 clk = ~clk;

    slowtime_counter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwroff_req(pwroff_req)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a == A_HI)   return {17'd0, m_cnt[46:32]};
        if (a == A_LO)   return m_cnt[31:0];
        if (a == A_CTRL) return m_ctrl;
        return 32'd0;
    endfunction

    function automatic logic [46:0] next_cnt(input logic [46:0] c, input logic t,
                                             input logic w, input logic [11:0] a,
                                             input logic [31:0] d);
        if (w && a == A_LO) return {c[46:32], d};
        if (w && a == A_HI) return {d[14:0], c[31:0]};
        if (t)              return c + 47'd1;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [46:0] act,
                         input logic [46:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock with the given inputs; model update and pulse check after edge
    task automatic step(input logic t, input logic w, input logic [11:0] a,
                        input logic [31:0] d);
        logic pulse_exp;
        tick_en = t; bus_we = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        m_cnt = next_cnt(m_cnt, t, w, a, d);
        if (w && a == A_CTRL) m_ctrl = d;
        pulse_exp = w && (a == A_CTRL) && d[5] && d[6];
        #1;
        check(pwroff_req == pulse_exp, "R9", 47'(pwroff_req), 47'(pulse_exp));
        tick_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input string req);
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0; bus_addr = a;
        #1;
        check(bus_rdata == exp_read(a), req, 47'(bus_rdata), 47'(exp_read(a)));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_out;
        seed_out = $urandom(32'h5EED_0042);
        // Reset with activity on the bus, which must be overridden (R1)
        tick_en = 1'b1; bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        rst_n = 1'b1;
        #1;
        check(pwroff_req == 1'b0, "R1", 47'(pwroff_req), 47'd0);
        read_chk(A_HI, "R1");
        read_chk(A_LO, "R1");
        read_chk(A_CTRL, "R1");

        // Plain ticks and idle cycles (R2, R3)
        @(negedge clk);
        repeat (5) step(1'b1, 1'b0, A_LO, 32'd0);
        read_chk(A_LO, "R2");
        @(negedge clk);
        repeat (3) step(1'b0, 1'b0, A_LO, 32'd0);
        read_chk(A_LO, "R2");
        read_chk(A_HI, "R3");

        // Lower patch and carry into the upper half (R4, R7)
        @(negedge clk);
        step(1'b0, 1'b1, A_LO, 32'hFFFF_FFFE);
        read_chk(A_LO, "R4");
        read_chk(A_HI, "R4");
        @(negedge clk);
        step(1'b1, 1'b0, A_LO, 32'd0);
        step(1'b1, 1'b0, A_LO, 32'd0);
        read_chk(A_HI, "R7");
        read_chk(A_LO, "R7");

        // Upper patch discards data bits above 14 (R5, R3)
        @(negedge clk);
        step(1'b0, 1'b1, A_HI, 32'hFFFF_FFFF);
        read_chk(A_HI, "R5");
        read_chk(A_LO, "R5");

        // Full wrap to zero (R7)
        @(negedge clk);
        step(1'b0, 1'b1, A_LO, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, A_LO, 32'd0);
        read_chk(A_HI, "R7");
        read_chk(A_LO, "R7");

        // Write with a tick in the same cycle, then keep counting (R6)
        @(negedge clk);
        step(1'b1, 1'b1, A_LO, 32'h1234_5678);
        read_chk(A_LO, "R6");
        @(negedge clk);
        step(1'b1, 1'b1, A_HI, 32'h0000_2AAA);
        read_chk(A_HI, "R6");
        @(negedge clk);
        step(1'b1, 1'b0, A_LO, 32'd0);
        read_chk(A_LO, "R6");

        // Control word and power-off qualifier (R8, R9)
        @(negedge clk);
        step(1'b0, 1'b1, A_CTRL, 32'h0000_0040);
        step(1'b0, 1'b1, A_CTRL, 32'h0000_0020);
        step(1'b0, 1'b1, A_CTRL, 32'hA5A5_F0F0);
        read_chk(A_CTRL, "R8");
        @(negedge clk);
        step(1'b0, 1'b1, A_CTRL, 32'h0000_0060);
        step(1'b0, 1'b0, A_CTRL, 32'd0);
        step(1'b0, 1'b1, A_LO, 32'h0000_0060);
        read_chk(A_CTRL, "R8");

        // Undecoded offsets: read zero, writes change nothing (R10)
        @(negedge clk);
        step(1'b0, 1'b1, 12'h058, 32'hDEAD_BEEF);
        step(1'b0, 1'b1, 12'h03C, 32'hCAFE_F00D);
        step(1'b0, 1'b1, 12'h000, 32'h1111_1111);
        step(1'b0, 1'b1, 12'hFFC, 32'h2222_2222);
        step(1'b0, 1'b1, 12'h051, 32'h3333_3333);
        read_chk(12'h058, "R10");
        read_chk(12'hFFC, "R10");
        read_chk(12'h051, "R10");
        read_chk(A_HI, "R10");
        read_chk(A_LO, "R10");
        read_chk(A_CTRL, "R10");

        // Seeded random traffic with a read after every step (R2-R10)
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic [11:0] ra;
            int unsigned pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1, 2: a = A_LO;
                3, 4:    a = A_HI;
                5, 6:    a = A_CTRL;
                default: a = 12'($urandom_range(0, 4095));
            endcase
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d = d | 32'h0000_0060;
            if (a == A_LO && $urandom_range(0, 3) == 0) d = 32'hFFFF_FFF0 | (d & 32'hF);
            pick = $urandom_range(0, 3);
            ra = (pick == 0) ? A_HI : (pick == 1) ? A_LO : (pick == 2) ? A_CTRL
                 : 12'($urandom_range(0, 4095));
            @(negedge clk);
            step(1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0), a, d);
            read_chk(ra, "R3");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule